// File: doc/BRIEF.md
# Triple-Oversampled Edge-Armed Serial Byte Receiver

This block recovers 8-N-1 asynchronous serial characters from a single input line. A sample tick runs at three times the bit rate. While the receiver waits, a falling edge on the synchronized line starts the capture of a fixed 29-sample word, collected least significant sample first. Each data bit is the centre sample of its group of three. When the word is complete, the recovered byte is presented with a one-cycle valid pulse and held until a consumer reads it.

The capture stops after the second of the three stop-bit samples, not the third. The receiver is therefore already waiting again during the final third of the stop bit. A sender whose characters run up to one third of a bit short keeps its framing: its early start bit is seen as a fresh edge and no sample of it is lost. The sample period is set at run time through a divisor input. A package function gives the divisor for a given system clock and bit rate.

Top module: `uart3x_rx`

## Requirements
- R1: The sample tick period is 2*(div_i+1) system clocks. A bit lasts three ticks. The divisor for system clock F and bit rate B is F/(2*B*3)-1, as given by the package function.
- R2: A capture starts only on a falling edge of the line while the receiver is waiting. The line passes through a two-flop synchronizer first. Falling edges inside a character do not start another capture.
- R3: One character is exactly 29 samples, numbered 0 to 28 from the first start-bit sample. The receiver waits again right after sample 28, so a start bit that begins within the last third of the stop bit is captured as the next character.
- R4: Bits arrive least significant first. Data bit n of rx_data is sample 3n+4, for n = 0 to 7. Bytes are recovered correctly when the bit length differs from nominal by up to 1/36 of a bit, and when the stop bit is shortened to two thirds.
- R5: rx_valid is high for exactly one clock per recovered character. rx_data carries the new byte from that same clock on.
- R6: rx_ready goes to 1 with each new byte. A one-clock rd pulse clears it. rd while rx_ready is 0 changes nothing.
- R7: rx_ovf goes to 1 when a byte completes while rx_ready is 1 and rd is not high in that clock. The newer byte replaces the held one. rx_ovf stays at 1 until ovf_clr is 1, and a new overflow in the clearing cycle wins. ovf_clr does not change rx_ready or rx_data.
- R8: After reset, rx_data is 0 and rx_valid, rx_ready and rx_ovf are all 0.
- R9: A changed divisor applies to the following characters. Bytes sent at the matching bit rate are recovered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_i | input | DIV_W | Sample divisor; tick period is 2*(div_i+1) clocks |
| rxd | input | 1 | Asynchronous serial line, idle high |
| rd | input | 1 | Read strobe, clears rx_ready |
| ovf_clr | input | 1 | Write-1 clear of rx_ovf |
| rx_data | output | 8 | Last recovered byte |
| rx_valid | output | 1 | One-clock pulse when a byte completes |
| rx_ready | output | 1 | An unread byte is held |
| rx_ovf | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach is a character whose stop bit ends one tick early, followed at once by the next start bit. That start edge falls between the last sample taken and the point where a 30-sample receiver would still be busy. The bench sends runs of back-to-back characters with stop bits shortened to two thirds of a bit and checks that each byte survives. It also sends random bytes with bit lengths one clock shorter or longer than nominal, so timing drift builds up across each character. It reaches overflow by turning off its automatic reader and sending two characters.

// File: rtl/uart3x_pkg.sv
package uart3x_pkg;

    localparam int OSR       = 3;
    localparam int DATA_W    = 8;
    localparam int SAMPLES   = 29;
    localparam int SCNT_W    = $clog2(SAMPLES);
    // clocks of delay between the line edge and the capture start
    localparam int EDGE_LAT  = 2;

    typedef enum logic [0:0] {
        ST_WAIT = 1'b0,
        ST_GRAB = 1'b1
    } grab_state_e;

    typedef struct packed {
        logic               done;
        logic [SAMPLES-1:0] word;
    } grab_t;

    function automatic int unsigned calc_divisor(input int unsigned sys_hz,
                                                 input int unsigned bit_hz);
        return sys_hz / (2 * bit_hz * OSR) - 1;
    endfunction

    // data bit n is the centre sample of group n+1
    function automatic logic [DATA_W-1:0] pick_byte(input logic [SAMPLES-1:0] w);
        logic [DATA_W-1:0] b;
        for (int n = 0; n < DATA_W; n++) begin
            b[n] = w[OSR*n + 4];
        end
        return b;
    endfunction

endpackage

// File: rtl/uart3x_tick.sv
module uart3x_tick
    import uart3x_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    input  logic             restart,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] first_load;
    logic [CNT_W-1:0] full_load;

    // half a sample period, less the synchronizer delay
    always_comb begin
        if (div_i > DIV_W'(EDGE_LAT))
            first_load = CNT_W'(div_i - DIV_W'(EDGE_LAT));
        else
            first_load = '0;
        full_load = {div_i, 1'b1};
    end

    assign tick = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= full_load;
        else if (restart)
            cnt <= first_load;
        else if (tick)
            cnt <= full_load;
        else
            cnt <= cnt - 1'b1;
    end

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart) |=> !tick);

endmodule

// File: rtl/uart3x_capture.sv
module uart3x_capture
    import uart3x_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rxd,
    input  logic  tick,
    output logic  restart,
    output grab_t grab
);
    logic [2:0]         sync_q;
    logic               line;
    logic               line_fall;
    grab_state_e        state;
    logic [SCNT_W-1:0]  scnt;
    logic [SAMPLES-1:0] shreg;
    logic               done_q;

    assign line      = sync_q[1];
    assign line_fall = !sync_q[1] && sync_q[2];
    assign restart   = (state == ST_WAIT) && line_fall;

    always_ff @(posedge clk) begin
        if (rst)
            sync_q <= '1;
        else
            sync_q <= {sync_q[1:0], rxd};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_WAIT;
            scnt   <= '0;
            shreg  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_WAIT: begin
                    scnt <= '0;
                    if (line_fall)
                        state <= ST_GRAB;
                end
                ST_GRAB: begin
                    if (tick) begin
                        shreg <= {line, shreg[SAMPLES-1:1]};
                        if (scnt == SCNT_W'(SAMPLES - 1)) begin
                            state  <= ST_WAIT;
                            done_q <= 1'b1;
                            scnt   <= '0;
                        end else begin
                            scnt <= scnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_WAIT;
            endcase
        end
    end

    assign grab.done = done_q;
    assign grab.word = shreg;

    // R2
    start_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(state == ST_GRAB) |-> $past(line_fall));

    // R3
    sample_bound_chk: assert property (@(posedge clk) disable iff (rst)
        scnt <= SCNT_W'(SAMPLES - 1));

    // R3
    rearm_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (state == ST_WAIT));

endmodule

// File: rtl/uart3x_holder.sv
module uart3x_holder
    import uart3x_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  grab_t             grab,
    input  logic              rd,
    input  logic              ovf_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_ready,
    output logic              rx_ovf
);
    logic collide;

    assign collide = grab.done && rx_ready && !rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_ready <= 1'b0;
            rx_ovf   <= 1'b0;
        end else begin
            rx_valid <= grab.done;
            if (grab.done)
                rx_data <= pick_byte(grab.word);

            if (grab.done)
                rx_ready <= 1'b1;
            else if (rd)
                rx_ready <= 1'b0;

            if (collide)
                rx_ovf <= 1'b1;
            else if (ovf_clr)
                rx_ovf <= 1'b0;
        end
    end

    // R5
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R6
    ready_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> rx_ready);

    // R6
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && !grab.done) |=> !rx_ready);

    // R7
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ovf) |-> rx_valid);

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_ovf) |-> $past(ovf_clr));

endmodule

// File: rtl/uart3x_rx.sv
module uart3x_rx
    import uart3x_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    input  logic             rxd,
    input  logic             rd,
    input  logic             ovf_clr,
    output logic [7:0]       rx_data,
    output logic             rx_valid,
    output logic             rx_ready,
    output logic             rx_ovf
);
    logic  tick;
    logic  restart;
    grab_t grab;

    uart3x_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .div_i   (div_i),
        .restart (restart),
        .tick    (tick)
    );

    uart3x_capture u_capture (
        .clk     (clk),
        .rst     (rst),
        .rxd     (rxd),
        .tick    (tick),
        .restart (restart),
        .grab    (grab)
    );

    uart3x_holder u_holder (
        .clk      (clk),
        .rst      (rst),
        .grab     (grab),
        .rd       (rd),
        .ovf_clr  (ovf_clr),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_ready (rx_ready),
        .rx_ovf   (rx_ovf)
    );

endmodule

// File: tb/test_uart3x_rx.sv
module test_uart3x_rx;
    import uart3x_pkg::*;

    localparam int DIV_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] div_i = '0;
    logic             rxd = 1'b1;
    logic             rd_auto = 1'b0;
    logic             rd_dir = 1'b0;
    logic             rd;
    logic             ovf_clr = 1'b0;
    logic [7:0]       rx_data;
    logic             rx_valid;
    logic             rx_ready;
    logic             rx_ovf;

    int n_cmp = 0;
    int n_bad = 0;
    bit auto_read = 1'b1;
    bit prev_valid = 1'b0;
    int n_recv = 0;
    logic [7:0] exp_q[$];

    assign rd = rd_auto | rd_dir;

    always #10 clk = ~clk;

    uart3x_rx #(.DIV_W(DIV_W)) i_uart3x_rx (
        .clk(clk), .rst(rst), .div_i(div_i), .rxd(rxd), .rd(rd),
        .ovf_clr(ovf_clr), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .rx_ovf(rx_ovf)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // bit length L clocks for start and data, stop length ls clocks
    task automatic send_byte(input logic [7:0] b, input int L, input int ls);
        exp_q.push_back(b);
        rxd = 1'b0;
        repeat (L) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (L) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (ls) @(negedge clk);
    endtask

    task automatic idle(input int n);
        rxd = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    // monitor and automatic reader
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                // R5: single-cycle pulse
                check("R5 pulse", {31'd0, prev_valid}, 32'd0);
                n_recv++;
                if (exp_q.size() == 0) begin
                    check("R4 unexpected byte", {24'd0, rx_data}, 32'hFFFF_FFFF);
                end else begin
                    check("R4 data", {24'd0, rx_data}, {24'd0, exp_q.pop_front()});
                end
            end
            prev_valid <= rx_valid;
            rd_auto <= auto_read && rx_valid;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        int unsigned seed_dummy;
        int sent;
        seed_dummy = $urandom(32'd20240611);
        // R1: divisor for 72 MHz system clock at 1 Mbit/s is 11; nominal used here is 5
        check("R1 divisor fn", calc_divisor(72_000_000, 1_000_000), 32'd11);
        div_i = DIV_W'(calc_divisor(36_000_000, 1_000_000));
        check("R1 divisor fn 5", {16'd0, div_i}, 32'd5);
        repeat (4) @(negedge clk);
        // R8: reset state
        check("R8 data", {24'd0, rx_data}, 32'd0);
        check("R8 valid", {31'd0, rx_valid}, 32'd0);
        check("R8 ready", {31'd0, rx_ready}, 32'd0);
        check("R8 ovf", {31'd0, rx_ovf}, 32'd0);
        rst = 1'b0;
        idle(20);

        // R4 directed patterns at nominal bit length (36 clocks)
        send_byte(8'h55, 36, 36);
        send_byte(8'h00, 36, 36);
        send_byte(8'hFF, 36, 36);
        send_byte(8'h81, 36, 36);
        idle(60);
        // R6: reader has cleared ready
        check("R6 ready cleared", {31'd0, rx_ready}, 32'd0);

        // R3: short stop bits (two thirds), back to back
        send_byte(8'hA5, 36, 24);
        send_byte(8'h3C, 36, 24);
        send_byte(8'h01, 36, 24);
        send_byte(8'hFE, 36, 24);
        send_byte(8'h80, 36, 24);
        send_byte(8'h7E, 36, 24);
        idle(60);
        check("R3 short-stop run drained", exp_q.size(), 32'd0);

        // R4 random bytes with bit-length drift and random gaps
        for (int k = 0; k < 40; k++) begin
            int L;
            L = 35 + int'($urandom_range(0, 2));
            send_byte(8'($urandom), L, L);
            idle(int'($urandom_range(0, 30)));
        end
        idle(60);
        check("R4 random drained", exp_q.size(), 32'd0);
        check("R7 no false overflow", {31'd0, rx_ovf}, 32'd0);

        // R7 overflow: no reader, two bytes
        auto_read = 1'b0;
        send_byte(8'h12, 36, 36);
        idle(40);
        check("R6 ready set", {31'd0, rx_ready}, 32'd1);
        check("R7 no ovf yet", {31'd0, rx_ovf}, 32'd0);
        send_byte(8'h34, 36, 36);
        idle(40);
        check("R7 ovf set", {31'd0, rx_ovf}, 32'd1);
        check("R7 newer byte kept", {24'd0, rx_data}, 32'h34);
        idle(10);
        check("R7 ovf sticky", {31'd0, rx_ovf}, 32'd1);
        ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0; @(negedge clk);
        check("R7 ovf cleared", {31'd0, rx_ovf}, 32'd0);
        check("R7 clear leaves ready", {31'd0, rx_ready}, 32'd1);
        check("R7 clear leaves data", {24'd0, rx_data}, 32'h34);
        rd_dir = 1'b1; @(negedge clk); rd_dir = 1'b0; @(negedge clk);
        check("R6 rd clears ready", {31'd0, rx_ready}, 32'd0);
        rd_dir = 1'b1; @(negedge clk); rd_dir = 1'b0; @(negedge clk);
        check("R6 rd when empty", {31'd0, rx_ready}, 32'd0);
        check("R6 rd when empty data", {24'd0, rx_data}, 32'h34);
        check("R6 rd when empty ovf", {31'd0, rx_ovf}, 32'd0);
        auto_read = 1'b1;

        // R9: divisor 2 -> bit length 18 clocks
        div_i = 16'd2;
        idle(10);
        send_byte(8'hC3, 18, 18);
        send_byte(8'h69, 18, 12);
        send_byte(8'h96, 18, 18);
        idle(40);
        check("R9 new rate drained", exp_q.size(), 32'd0);

        sent = 4 + 6 + 40 + 2 + 3;
        check("R3 no byte lost", n_recv, sent);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule